// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by an amount taken from a second register operand, as a data-processing unit does when the shift count is not an immediate. Four operations are offered: logical left, logical right, arithmetic right and rotate right. Next to the shifted word it produces the carry-out that a flags register would take. It also produces a strobe that tells that flags register whether to load the carry at all.

The carry follows exact rules at the edges of the range. A zero amount leaves both the word and the carry alone. An amount of exactly the word width and an amount above it give different carries for the logical shifts. Rotate keeps only the low five bits of the amount, but it still tells a true zero from a nonzero multiple of 32.

Operands enter through a valid/ready stream and results leave through another. With the default `PIPE=1`, a one-entry output register sits between the two. The input is ready whenever that register is empty or is being drained in the same cycle. A result stays frozen on the output while `out_ready` is low. Once `in_valid` is raised, the upstream side must hold it and the operand fields steady until the transfer happens. With `PIPE=0` the path is combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.

Top module: `shft_reg_shifter`

## Requirements
- R1: Only bits [7:0] of `in_amount` form the shift count N. Bits [31:8] have no effect on `out_result`, `out_carry` or `out_carry_load`.
- R2: When N is 0, for every `in_kind`, `out_result` equals `in_value`, `out_carry` equals `in_carry` and `out_carry_load` is 0.
- R3: `out_carry_load` is 1 exactly when N is nonzero.
- R4: Kind 2'b00 (logical left) with N in 1..31 gives `in_value << N`, and the carry is `in_value` bit 32−N.
- R5: Kind 2'b00 with N = 32 gives 0 with carry `in_value` bit 0. With N > 32 it gives 0 with carry 0.
- R6: Kind 2'b01 (logical right) with N in 1..31 gives `in_value >> N`, and the carry is `in_value` bit N−1.
- R7: Kind 2'b01 with N = 32 gives 0 with carry `in_value` bit 31. With N > 32 it gives 0 with carry 0.
- R8: Kind 2'b10 (arithmetic right) with N in 1..31 gives the sign-filled shift with carry bit N−1. With N ≥ 32 it gives 32 copies of bit 31, and the carry is bit 31.
- R9: Kind 2'b11 (rotate right) with M = N mod 32 nonzero gives `in_value` rotated right by M, and the carry is bit M−1.
- R10: Kind 2'b11 with N nonzero and M = 0 gives `in_value` unchanged, and the carry is bit 31.
- R11: With `PIPE=1`, a transfer accepted at a clock edge appears on the outputs with `out_valid` high after that edge. `in_ready` is high whenever the output is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold steady.
- R12: While `rst_n` is low and after its release, `out_valid` is 0 until the first input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_value | input | 32 | Word to shift |
| in_amount | input | 32 | Amount register; only bits [7:0] are used |
| in_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | New carry value |
| out_carry_load | output | 1 | Flags register should load `out_carry` |

## Verification
The bench drives the counts 0, 1, 31, 32, 33, 255 and the multiples of 32 for every kind. A design that treats 32 like "above 32" loses the carry from bit 0 or bit 31. A design that lets rotate by 32 fall into the zero case keeps the old carry instead of taking bit 31. A design with an off-by-one carry index fails at a count of 1 or 31.

Amounts with upper bits set, such as 0x100 and 0x120, expose a decoder that reads more than the low byte. Such a decoder would report a large shift where a zero or a 32 is expected. Random back-pressure checks that a stalled result does not change and that no transfer is lost or duplicated.

// File: rtl/shft_pkg.sv
package shft_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_t;

  // Range class of the 8-bit count against the word width
  typedef struct packed {
    logic zero;   // count == 0
    logic below;  // 1 .. width-1
    logic exact;  // count == width
    logic above;  // count > width
  } amt_class_t;

endpackage

// File: rtl/shft_amount_class.sv
module shft_amount_class
  import shft_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int SH_BITS = $clog2(W)
) (
  input  logic [AMT_W-1:0]   amt,
  output amt_class_t         cls,
  output logic [SH_BITS-1:0] low
);

  localparam logic [AMT_W-1:0] WIDTH_CNT = AMT_W'(W);

  always_comb begin
    cls.zero  = (amt == '0);
    cls.exact = (amt == WIDTH_CNT);
    cls.above = (amt > WIDTH_CNT);
    cls.below = (amt != '0) && (amt < WIDTH_CNT);
    low       = amt[SH_BITS-1:0];
  end

endmodule

// File: rtl/shft_datapath.sv
module shft_datapath
  import shft_pkg::*;
#(
  parameter int W = 32,
  localparam int SH_BITS = $clog2(W)
) (
  input  logic [W-1:0]       value,
  input  shift_kind_t        kind,
  input  amt_class_t         cls,
  input  logic [SH_BITS-1:0] low,
  output logic [W-1:0]       result
);

  logic [W-1:0]   lsl_v, lsr_v, asr_v, rot_v, sign_fill;
  logic [2*W-1:0] doubled;

  always_comb begin
    lsl_v     = value << low;
    lsr_v     = value >> low;
    asr_v     = W'($signed(value) >>> low);
    doubled   = {value, value} >> low;
    rot_v     = doubled[W-1:0];
    sign_fill = {W{value[W-1]}};

    unique case (kind)
      SK_LSL:  result = cls.zero ? value : (cls.below ? lsl_v : '0);
      SK_LSR:  result = cls.zero ? value : (cls.below ? lsr_v : '0);
      SK_ASR:  result = cls.zero ? value : (cls.below ? asr_v : sign_fill);
      default: result = rot_v;  // low == 0 yields value unchanged
    endcase
  end

endmodule

// File: rtl/shft_carry_sel.sv
module shft_carry_sel
  import shft_pkg::*;
#(
  parameter int W = 32,
  localparam int SH_BITS = $clog2(W)
) (
  input  logic [W-1:0]       value,
  input  shift_kind_t        kind,
  input  amt_class_t         cls,
  input  logic [SH_BITS-1:0] low,
  input  logic               carry_in,
  output logic               carry_out
);

  logic [SH_BITS-1:0] left_idx, right_idx;

  always_comb begin
    // last bit pushed out on the left is bit W-N, i.e. -N modulo W
    left_idx  = SH_BITS'(0) - low;
    right_idx = low - SH_BITS'(1);

    if (cls.zero) begin
      carry_out = carry_in;
    end else begin
      unique case (kind)
        SK_LSL:  carry_out = cls.below ? value[left_idx]
                           : (cls.exact ? value[0] : 1'b0);
        SK_LSR:  carry_out = cls.below ? value[right_idx]
                           : (cls.exact ? value[W-1] : 1'b0);
        SK_ASR:  carry_out = cls.below ? value[right_idx] : value[W-1];
        default: carry_out = (low == '0) ? value[W-1] : value[right_idx];
      endcase
    end
  end

endmodule

// File: rtl/shft_reg_shifter.sv
module shft_reg_shifter
  import shft_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter bit PIPE  = 1'b1,
  localparam int SH_BITS = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_value,
  input  logic [W-1:0] in_amount,
  input  logic [1:0]   in_kind,
  input  logic         in_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_carry,
  output logic         out_carry_load
);

  logic [AMT_W-1:0]   amt;
  logic               amt_unused;
  amt_class_t         cls;
  logic [SH_BITS-1:0] low;
  shift_kind_t        kind;
  logic [W-1:0]       c_result;
  logic               c_carry;
  logic               c_load;

  assign amt        = in_amount[AMT_W-1:0];
  assign amt_unused = ^in_amount[W-1:AMT_W];
  assign kind       = shift_kind_t'(in_kind);
  assign c_load     = ~cls.zero;

  shft_amount_class #(.W(W), .AMT_W(AMT_W)) u_class (
    .amt (amt),
    .cls (cls),
    .low (low)
  );

  shft_datapath #(.W(W)) u_data (
    .value  (in_value),
    .kind   (kind),
    .cls    (cls),
    .low    (low),
    .result (c_result)
  );

  shft_carry_sel #(.W(W)) u_carry (
    .value     (in_value),
    .kind      (kind),
    .cls       (cls),
    .low       (low),
    .carry_in  (in_carry),
    .carry_out (c_carry)
  );

  generate
    if (PIPE) begin : g_reg
      logic         r_valid;
      logic [W-1:0] r_result;
      logic         r_carry;
      logic         r_load;

      assign in_ready = ~r_valid | out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r_valid <= 1'b0;
        end else if (in_ready) begin
          r_valid <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          r_result <= c_result;
          r_carry  <= c_carry;
          r_load   <= c_load;
        end
      end

      assign out_valid      = r_valid;
      assign out_result     = r_result;
      assign out_carry      = r_carry;
      assign out_carry_load = r_load;
    end else begin : g_comb
      assign in_ready       = out_ready;
      assign out_valid      = in_valid;
      assign out_result     = c_result;
      assign out_carry      = c_carry;
      assign out_carry_load = c_load;
    end
  endgenerate

endmodule

// File: rtl/shft_reg_shifter_chk.sv
module shft_reg_shifter_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter bit PIPE  = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_value,
  input logic [W-1:0] in_amount,
  input logic [1:0]   in_kind,
  input logic         in_carry,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_carry,
  input logic         out_carry_load
);

  logic [AMT_W-1:0] amt;
  logic             chk_unused;
  logic             fire;

  assign amt        = in_amount[AMT_W-1:0];
  assign chk_unused = ^in_amount[W-1:AMT_W];
  assign fire       = in_valid & in_ready;

  generate
    if (PIPE) begin : g_reg_chk
      // R12
      reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

      // R11
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result)
          && $stable(out_carry) && $stable(out_carry_load));

      // R11
      empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      // R2
      zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && amt == '0 |=> out_valid && !out_carry_load
          && out_result == $past(in_value) && out_carry == $past(in_carry));

      // R3
      load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && amt != '0 |=> out_valid && out_carry_load);

      // R5
      lsl_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_kind == 2'b00 && amt > AMT_W'(W) |=> out_result == '0 && !out_carry);

      // R8
      asr_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_kind == 2'b10 && amt >= AMT_W'(W)
          |=> out_result == {W{$past(in_value[W-1])}} && out_carry == $past(in_value[W-1]));
    end
  endgenerate

endmodule

bind shft_reg_shifter shft_reg_shifter_chk #(.W(W), .AMT_W(AMT_W), .PIPE(PIPE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_value       (in_value),
  .in_amount      (in_amount),
  .in_kind        (in_kind),
  .in_carry       (in_carry),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_result     (out_result),
  .out_carry      (out_carry),
  .out_carry_load (out_carry_load)
);

// File: tb/tb_shft_reg_shifter.sv
`timescale 1ns/1ps
module tb_shft_reg_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic [31:0] in_amount = '0;
  logic [1:0]  in_kind = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_carry_load;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  shft_reg_shifter dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_amount(in_amount),
    .in_kind(in_kind), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry),
    .out_carry_load(out_carry_load)
  );

  // stimulus list
  logic [31:0] s_val[$];
  logic [31:0] s_amt[$];
  logic [1:0]  s_kind[$];
  logic        s_cin[$];

  // expected results in flight
  logic [31:0] e_res[$];
  logic        e_c[$];
  logic        e_ld[$];
  string       e_tag[$];

  task automatic add(input logic [31:0] v, input logic [31:0] a,
                     input logic [1:0] k, input logic c);
    s_val.push_back(v); s_amt.push_back(a); s_kind.push_back(k); s_cin.push_back(c);
  endtask

  // Behavioural model: one bit position per step
  task automatic model(input logic [31:0] x, input logic [31:0] amount,
                       input logic [1:0] k, input logic cin,
                       output logic [31:0] r, output logic c, output logic ld,
                       output string tag);
    int n = int'(amount & 32'hff);
    int m = n % 32;
    r = x; c = cin; ld = (n != 0);
    case (k)
      2'b00: for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
      2'b01: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
      2'b10: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      default: begin
        if (n != 0 && m == 0) c = x[31];
        else for (int i = 0; i < m; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      end
    endcase
    if (amount[31:8] != 0)      tag = "R1";
    else if (n == 0)            tag = "R2";
    else if (k == 2'b00)        tag = (n < 32) ? "R4" : "R5";
    else if (k == 2'b01)        tag = (n < 32) ? "R6" : "R7";
    else if (k == 2'b10)        tag = "R8";
    else                        tag = (m != 0) ? "R9" : "R10";
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  bit timed_out = 0;
  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
  end

  initial begin
    int idx = 0;
    bit have = 0;
    bit accepted = 0;
    bit stalled = 0;
    logic [31:0] sv_res;
    logic sv_c, sv_ld;

    // directed corners
    for (int k = 0; k < 4; k++) begin
      add(32'h8000_0001, 32'd0, 2'(k), 1'b1);
      add(32'h8000_0001, 32'd0, 2'(k), 1'b0);
      add(32'hA5A5_F00F, 32'h0000_0100, 2'(k), 1'b1); // R1 low byte zero
      add(32'h8000_0001, 32'h0000_0120, 2'(k), 1'b0); // R1 low byte 32
    end
    add(32'h8000_0001, 32'd1,   2'b00, 1'b0);
    add(32'h0000_0003, 32'd31,  2'b00, 1'b0);
    add(32'h0000_0001, 32'd32,  2'b00, 1'b0);
    add(32'hFFFF_FFFF, 32'd33,  2'b00, 1'b1);
    add(32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1);
    add(32'h8000_0001, 32'd1,   2'b01, 1'b0);
    add(32'hC000_0000, 32'd31,  2'b01, 1'b0);
    add(32'h8000_0000, 32'd32,  2'b01, 1'b0);
    add(32'hFFFF_FFFF, 32'd33,  2'b01, 1'b1);
    add(32'h8000_0000, 32'd4,   2'b10, 1'b0);
    add(32'h8000_0000, 32'd32,  2'b10, 1'b0);
    add(32'h7FFF_FFFF, 32'd40,  2'b10, 1'b1);
    add(32'h8000_0000, 32'd255, 2'b10, 1'b0);
    add(32'h8000_0001, 32'd1,   2'b11, 1'b0);
    add(32'h8000_0001, 32'd33,  2'b11, 1'b0);
    add(32'h8000_0001, 32'd32,  2'b11, 1'b0);
    add(32'h0000_0001, 32'd64,  2'b11, 1'b1);
    add(32'h8000_0000, 32'd224, 2'b11, 1'b0);
    add(32'h1234_5678, 32'd31,  2'b11, 1'b0);
    for (int i = 0; i < 500; i++) begin
      logic [31:0] a;
      case ($urandom % 6)
        0: a = 32'($urandom % 32);
        1: a = 32'(32 * ($urandom % 8));
        2: a = 32'(32 + ($urandom % 3));
        3: a = $urandom;
        default: a = 32'($urandom % 256);
      endcase
      add($urandom, a, 2'($urandom % 4), 1'($urandom % 2));
    end

    // reset
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", 32'(out_valid), 32'd0);

    while (!timed_out && (idx < s_val.size() || have || e_res.size() != 0)) begin
      @(negedge clk);
      // outputs after the last edge
      if (stalled) begin
        chk(out_valid && out_result == sv_res && out_carry == sv_c && out_carry_load == sv_ld,
            "R11", "stalled output moved", out_result, sv_res);
      end
      if (e_res.size() != 0) begin
        chk(out_valid == 1'b1, "R11", "out_valid", 32'(out_valid), 32'd1);
        chk(out_result == e_res[0], e_tag[0], "result", out_result, e_res[0]);
        chk(out_carry == e_c[0], e_tag[0], "carry", 32'(out_carry), 32'(e_c[0]));
        chk(out_carry_load == e_ld[0], "R3", "carry_load", 32'(out_carry_load), 32'(e_ld[0]));
      end else begin
        chk(out_valid == 1'b0, "R11", "spurious out_valid", 32'(out_valid), 32'd0);
      end

      // new inputs
      if (accepted) begin in_valid = 1'b0; accepted = 0; end
      if (!have && idx < s_val.size()) begin
        in_value = s_val[idx]; in_amount = s_amt[idx];
        in_kind = s_kind[idx]; in_carry = s_cin[idx];
        idx++; have = 1;
      end
      if (!in_valid && have) in_valid = ($urandom % 5) != 0;
      out_ready = (idx < 60) ? 1'b1 : (($urandom % 10) < 6);
      #1;
      if (!out_valid || out_ready)
        chk(in_ready == 1'b1, "R11", "in_ready", 32'(in_ready), 32'd1);
      stalled = out_valid && !out_ready;
      sv_res = out_result; sv_c = out_carry; sv_ld = out_carry_load;
      if (out_valid && out_ready && e_res.size() != 0) begin
        void'(e_res.pop_front()); void'(e_c.pop_front());
        void'(e_ld.pop_front()); void'(e_tag.pop_front());
      end
      if (in_valid && in_ready) begin
        logic [31:0] r; logic c, ld; string t;
        model(in_value, in_amount, in_kind, in_carry, r, c, ld, t);
        e_res.push_back(r); e_c.push_back(c); e_ld.push_back(ld); e_tag.push_back(t);
        have = 0; accepted = 1;
      end
    end

    if (timed_out) begin
      failures++;
      checks++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", e_res.size(), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule